// File: doc/BRIEF.md
# Pipelined No-Wait Synchronous SRAM

This block is a cycle-accurate, synthesizable model of a synchronous static RAM. The array sits behind a two-stage pipeline, so a read and a write have the same latency. A read's data appears two enabled clocks after its address is captured. A write's data is taken from the data bus two enabled clocks after its address. Because both directions use the same slot, the bus can switch between reading and writing on any cycle and no idle cycle is ever inserted.

Every synchronous input is captured on the rising clock edge. Each cycle either loads a fresh address and starts a new read, write or deselect, or it advances a 2-bit burst offset and continues the previous cycle type. The burst runs in linear order or in interleaved order. Each data lane has its own write enable. A stall input freezes the whole block.

Writes are posted: they reach the array one slot later than they are accepted. A read of a word that still has a write in flight returns the newer bytes, merged lane by lane. The shared data bus is split into `din`, `dout` and the drive enable `dout_oe`.

Top module: `nowait_pipe_sram`

## Requirements
- R1: While reset is asserted and after it is released, `dout_oe` is low until a read slot reaches the output.
- R2: An enabled edge with `adv` low loads `addr` and starts a new cycle. The cycle is selected only when `en_a_n`=0, `en_b`=1 and `en_c_n`=0. A selected cycle is a write if `wr_n`=0 and a read if `wr_n`=1. Any other chip-enable combination gives a deselect.
- R3: For a read issued at enabled edge e, `dout` carries the word and `dout_oe` is high after enabled edge e+2. The output holds for one enabled cycle per read slot.
- R4: For a write issued at enabled edge e, `din` is sampled at enabled edge e+2. Lane i, which is bits [i*LANE_W +: LANE_W], is written only if `lane_wr_n[i]`=0 at edge e. Edge e may be a load or an advance.
- R5: An enabled edge with `adv` high steps the burst offset and continues the previous cycle type, including deselect. It leaves address bits above bit 1 unchanged, and it ignores `wr_n` and the chip enables.
- R6: With `ilv_mode`=0 at the load edge, burst step k addresses offset (start + k) mod 4.
- R7: With `ilv_mode`=1 at the load edge, burst step k addresses offset start XOR k. The mode is held for the whole burst.
- R8: An edge with `stall` high is ignored. All inputs are disregarded, including `din`, and `dout`, `dout_oe` and every internal register keep their values.
- R9: Reads and writes may alternate in any order with no idle cycles. A read always returns the most recent data for each lane, including writes that are still pending.
- R10: `dout_oe` is low in every write and deselect slot.
- R11: The burst offset wraps, so the fifth step of a burst returns to the start offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline and burst state |
| stall | input | 1 | High freezes the block for this edge |
| adv | input | 1 | High advances the burst; low loads a new address |
| wr_n | input | 1 | Low selects a write on a load edge |
| ilv_mode | input | 1 | High selects interleaved burst order at load |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| addr | input | ADDR_W | Word address |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| din | input | LANES*LANE_W | Write data bus |
| dout | output | LANES*LANE_W | Read data bus |
| dout_oe | output | 1 | Drive enable for `dout` |

## Verification
The bench builds the block with its defaults: 8 address bits and two 9-bit lanes. With a 256-word array, every word fits in the reference model. The random phase confines its addresses to 32 words, which makes writes still in flight to the same address, partial-lane merges and bursts that wrap inside a block of four common rather than rare. The two lanes are enough to exercise a write that covers only some lanes.

// File: rtl/nwsram_pkg.sv
package nwsram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    localparam int BURST_W = 2;

endpackage

// File: rtl/nwsram_burst.sv
module nwsram_burst
    import nwsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              adv,
    input  logic              sel,
    input  logic              wr_n,
    input  logic              ilv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_wr_n,
    output op_e               cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LANES-1:0]  cmd_lanes
);

    localparam int OFF_W = BURST_W;
    localparam int HI_W  = ADDR_W - OFF_W;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [OFF_W-1:0]  step;
        logic              ilv;
        op_e               op;
    } bst_t;

    bst_t             st_d, st_q;
    logic [OFF_W-1:0] off;
    logic [HI_W-1:0]  hi;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.step = st_q.step + 2'd1;
        end else begin
            st_d.base = addr;
            st_d.step = '0;
            st_d.ilv  = ilv;
            if (!sel)
                st_d.op = OP_IDLE;
            else if (wr_n)
                st_d.op = OP_RD;
            else
                st_d.op = OP_WR;
        end
        if (st_d.ilv)
            off = st_d.base[OFF_W-1:0] ^ st_d.step;
        else
            off = st_d.base[OFF_W-1:0] + st_d.step;
        hi        = st_d.base[ADDR_W-1:OFF_W];
        cmd_addr  = {hi, off};
        cmd_op    = st_d.op;
        cmd_lanes = (st_d.op == OP_WR) ? ~lane_wr_n : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{base: '0, step: '0, ilv: 1'b0, op: OP_IDLE};
        else if (en)
            st_q <= st_d;
    end

    AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && adv) |=> $stable(st_q.base)); // R5
    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && adv) |=> (st_q.step == $past(st_q.step) + 2'd1)); // R11
    AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !adv) |=> (st_q.step == '0)); // R2
    AST_FROZEN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(st_q)); // R8

endmodule

// File: rtl/nwsram_array.sv
module nwsram_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
)(
    input  logic                      clk,
    input  logic [LANES-1:0]          we_lanes,
    input  logic [ADDR_W-1:0]         waddr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    input  logic [ADDR_W-1:0]         raddr,
    output logic [LANES*LANE_W-1:0]   rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we_lanes[g])
                cells[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
    end

endmodule

// File: rtl/nwsram_pipe.sv
module nwsram_pipe
    import nwsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
)(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  op_e                     cmd_op,
    input  logic [ADDR_W-1:0]       cmd_addr,
    input  logic [LANES-1:0]        cmd_lanes,
    input  logic [LANES*LANE_W-1:0] din,
    input  logic [LANES*LANE_W-1:0] rd_data,
    output logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES-1:0]        wr_lanes,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_oe
);

    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  lanes;
    } slot_t;

    typedef struct packed {
        slot_t             s1;
        slot_t             s2;
        logic              pw_v;
        logic [ADDR_W-1:0] pw_addr;
        logic [LANES-1:0]  pw_lanes;
        logic [DATA_W-1:0] pw_data;
        logic [DATA_W-1:0] dout;
        logic              oe;
    } pst_t;

    pst_t              st_d, st_q;
    logic              hit;
    logic [DATA_W-1:0] merged;

    always_comb begin
        rd_addr = st_q.s2.addr;
        hit     = st_q.pw_v && (st_q.pw_addr == st_q.s2.addr);
        merged  = rd_data;
        for (int g = 0; g < LANES; g++) begin
            if (hit && st_q.pw_lanes[g])
                merged[g*LANE_W +: LANE_W] = st_q.pw_data[g*LANE_W +: LANE_W];
        end

        st_d    = st_q;
        st_d.s1 = '{op: cmd_op, addr: cmd_addr, lanes: cmd_lanes};
        st_d.s2 = st_q.s1;
        st_d.pw_v = (st_q.s2.op == OP_WR);
        if (st_q.s2.op == OP_WR) begin
            st_d.pw_addr  = st_q.s2.addr;
            st_d.pw_lanes = st_q.s2.lanes;
            st_d.pw_data  = din;
        end
        st_d.oe = (st_q.s2.op == OP_RD);
        if (st_q.s2.op == OP_RD)
            st_d.dout = merged;

        wr_lanes = (en && st_q.pw_v) ? st_q.pw_lanes : '0;
        wr_addr  = st_q.pw_addr;
        wr_data  = st_q.pw_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else if (en)
            st_q <= st_d;
    end

    assign dout    = st_q.dout;
    assign dout_oe = st_q.oe;

    AST_READ_PRESENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_q.s2.op == OP_RD) |=> dout_oe); // R3
    AST_QUIET_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_q.s2.op != OP_RD) |=> !dout_oe); // R10
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(dout) && $stable(dout_oe) && $stable(st_q.pw_v))); // R8
    AST_POST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_q.s2.op == OP_WR) |=> (st_q.pw_v && st_q.pw_addr == $past(st_q.s2.addr))); // R4

endmodule

// File: rtl/nowait_pipe_sram.sv
module nowait_pipe_sram
    import nwsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
)(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    stall,
    input  logic                    adv,
    input  logic                    wr_n,
    input  logic                    ilv_mode,
    input  logic                    en_a_n,
    input  logic                    en_b,
    input  logic                    en_c_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_oe
);

    localparam int DATA_W = LANES * LANE_W;

    logic              en;
    logic              sel;
    op_e               cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic [LANES-1:0]  cmd_lanes;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic [LANES-1:0]  wr_lanes;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    assign en  = !stall;
    assign sel = !en_a_n && en_b && !en_c_n;

    nwsram_burst #(.ADDR_W(ADDR_W), .LANES(LANES)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .adv       (adv),
        .sel       (sel),
        .wr_n      (wr_n),
        .ilv       (ilv_mode),
        .addr      (addr),
        .lane_wr_n (lane_wr_n),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_lanes (cmd_lanes)
    );

    nwsram_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_lanes (cmd_lanes),
        .din       (din),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_lanes  (wr_lanes),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .dout      (dout),
        .dout_oe   (dout_oe)
    );

    nwsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk      (clk),
        .we_lanes (wr_lanes),
        .waddr    (wr_addr),
        .wdata    (wr_data),
        .raddr    (rd_addr),
        .rdata    (rd_data)
    );

    AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !adv && !sel) |=> (cmd_lanes == '0 || !adv || stall)); // R2

endmodule

// File: tb/nowait_pipe_sram_tb.sv
`timescale 1ns/1ps
module nowait_pipe_sram_tb;

    localparam int ADDR_W = 8;
    localparam int LANES  = 2;
    localparam int LANE_W = 9;
    localparam int DW     = LANES * LANE_W;
    localparam logic [2:0] CE_ON = 3'b010;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stall = 1'b0;
    logic          adv = 1'b0;
    logic          wr_n = 1'b1;
    logic          ilv_mode = 1'b0;
    logic [2:0]    ce = 3'b111;
    logic [ADDR_W-1:0] addr = '0;
    logic [LANES-1:0]  lane_wr_n = '1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_oe;

    always #2 clk = ~clk;

    nowait_pipe_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall     (stall),
        .adv       (adv),
        .wr_n      (wr_n),
        .ilv_mode  (ilv_mode),
        .en_a_n    (ce[2]),
        .en_b      (ce[1]),
        .en_c_n    (ce[0]),
        .addr      (addr),
        .lane_wr_n (lane_wr_n),
        .din       (din),
        .dout      (dout),
        .dout_oe   (dout_oe)
    );

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";

    // behavioural reference model
    logic [DW-1:0]    mem_m   [int];
    logic [LANES-1:0] known_m [int];
    int               p_op [2];
    int               p_addr [2];
    logic [LANES-1:0] p_ln [2];
    int               b_base, b_step, b_op, off, ea;
    logic             b_ilv;
    logic             exp_oe = 1'b0;
    logic [DW-1:0]    exp_dout = '0;
    logic [DW-1:0]    exp_mask = '0;
    logic [DW-1:0]    tmp;
    logic [LANES-1:0] kn;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_op[0] = 0; p_op[1] = 0; p_addr[0] = 0; p_addr[1] = 0;
            p_ln[0] = '0; p_ln[1] = '0;
            b_base = 0; b_step = 0; b_op = 0; b_ilv = 1'b0;
            exp_oe = 1'b0;
        end else if (!stall) begin
            ea = p_addr[1];
            exp_oe = (p_op[1] == 1);
            if (p_op[1] == 1) begin
                exp_dout = mem_m.exists(ea) ? mem_m[ea] : '0;
                kn = known_m.exists(ea) ? known_m[ea] : '0;
                exp_mask = '0;
                for (int l = 0; l < LANES; l++)
                    if (kn[l]) exp_mask[l*LANE_W +: LANE_W] = '1;
            end else if (p_op[1] == 2) begin
                tmp = mem_m.exists(ea) ? mem_m[ea] : '0;
                kn = known_m.exists(ea) ? known_m[ea] : '0;
                for (int l = 0; l < LANES; l++)
                    if (p_ln[1][l]) begin
                        tmp[l*LANE_W +: LANE_W] = din[l*LANE_W +: LANE_W];
                        kn[l] = 1'b1;
                    end
                mem_m[ea] = tmp;
                known_m[ea] = kn;
            end
            if (!adv) begin
                b_base = int'(addr); b_step = 0; b_ilv = ilv_mode;
                b_op = (ce == CE_ON) ? (wr_n ? 1 : 2) : 0;
            end else begin
                b_step = (b_step + 1) % 4;
            end
            off = b_ilv ? ((b_base % 4) ^ b_step) : (((b_base % 4) + b_step) % 4);
            p_op[1] = p_op[0]; p_addr[1] = p_addr[0]; p_ln[1] = p_ln[0];
            p_op[0] = b_op;
            p_addr[0] = (b_base / 4) * 4 + off;
            p_ln[0] = (b_op == 2) ? ~lane_wr_n : '0;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        checks++;
        if (dout_oe !== exp_oe) begin
            fails++;
            $display("FAIL %s: dout_oe=%0b expected %0b at %0t", cur_req, dout_oe, exp_oe, $time);
        end else if (exp_oe && (((dout ^ exp_dout) & exp_mask) != '0)) begin
            fails++;
            $display("FAIL %s: dout=%h expected %h (mask %h) at %0t",
                     cur_req, dout, exp_dout, exp_mask, $time);
        end
    end

    task automatic drv(input logic a_adv, input logic a_wr_n, input logic [2:0] a_ce,
                       input int a_addr, input logic [LANES-1:0] a_lwn,
                       input logic a_ilv, input logic a_stall);
        @(negedge clk);
        adv = a_adv; wr_n = a_wr_n; ce = a_ce; addr = a_addr[ADDR_W-1:0];
        lane_wr_n = a_lwn; ilv_mode = a_ilv; stall = a_stall;
        din = DW'($urandom);
    endtask

    task automatic wr(input int a, input logic [LANES-1:0] lwn);
        drv(1'b0, 1'b0, CE_ON, a, lwn, 1'b0, 1'b0);
    endtask

    task automatic rd(input int a);
        drv(1'b0, 1'b1, CE_ON, a, '1, 1'b0, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drv(1'b0, 1'b1, 3'b111, 0, '1, 1'b0, 1'b0);
    endtask

    task automatic burst(input logic is_wr, input int a, input logic ilv, input int steps);
        drv(1'b0, !is_wr, CE_ON, a, '0, ilv, 1'b0);
        for (int i = 0; i < steps; i++) drv(1'b1, 1'b1, 3'b111, 0, '0, !ilv, 1'b0);
    endtask

    initial begin
        #(200000 * 4);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        cur_req = "R1";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(3);

        cur_req = "R4";
        for (int a = 0; a < 16; a++) wr(a, 2'b00);
        cur_req = "R3";
        for (int a = 0; a < 16; a++) rd(a);
        idle(3);

        cur_req = "R4";
        wr(4, 2'b10); wr(5, 2'b01); wr(6, 2'b11);
        rd(4); rd(5); rd(6);
        idle(3);

        cur_req = "R9";
        wr(20, 2'b00); rd(20); wr(20, 2'b10); rd(20); wr(21, 2'b00); rd(20);
        rd(21); wr(20, 2'b01); wr(20, 2'b10); rd(20); wr(22, 2'b00); rd(22);
        idle(3);

        cur_req = "R6";
        burst(1'b1, 9, 1'b0, 3);
        burst(1'b0, 9, 1'b0, 3);
        cur_req = "R11";
        burst(1'b0, 6, 1'b0, 6);
        idle(3);

        cur_req = "R7";
        burst(1'b1, 8'h13, 1'b1, 3);
        burst(1'b0, 8'h12, 1'b1, 3);
        burst(1'b0, 8'h11, 1'b1, 4);
        idle(3);

        cur_req = "R5";
        burst(1'b1, 32, 1'b0, 2);
        burst(1'b0, 33, 1'b1, 3);
        idle(3);

        cur_req = "R2";
        drv(1'b0, 1'b0, 3'b110, 0, '0, 1'b0, 1'b0);
        drv(1'b0, 1'b0, 3'b000, 1, '0, 1'b0, 1'b0);
        drv(1'b0, 1'b0, 3'b011, 2, '0, 1'b0, 1'b0);
        drv(1'b1, 1'b0, CE_ON, 2, '0, 1'b0, 1'b0);
        drv(1'b1, 1'b0, CE_ON, 2, '0, 1'b0, 1'b0);
        cur_req = "R10";
        idle(2);
        for (int a = 0; a < 4; a++) rd(a);
        idle(3);

        cur_req = "R8";
        rd(7);
        for (int i = 0; i < 4; i++) drv(1'b0, 1'b0, CE_ON, 7, 2'b00, 1'b0, 1'b1);
        rd(8);
        wr(9, 2'b00);
        for (int i = 0; i < 3; i++) drv(1'b0, 1'b1, CE_ON, 9, '1, 1'b0, 1'b1);
        rd(9);
        for (int i = 0; i < 3; i++) drv(1'b1, 1'b0, CE_ON, 3, 2'b00, 1'b1, 1'b1);
        rd(9); rd(7);
        idle(3);

        cur_req = "R9";
        for (int i = 0; i < 400; i++) begin
            drv(($urandom % 3) == 0,
                ($urandom % 2) == 0,
                (($urandom % 4) == 0) ? 3'($urandom) : CE_ON,
                int'($urandom % 32),
                LANES'($urandom),
                ($urandom % 2) == 1,
                ($urandom % 5) == 0);
        end
        idle(4);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule